// File: doc/BRIEF.md
# Predicate Shadow Resolution Unit

This unit sits beside a scoreboard-style issue engine and decides the fate of vectorised element operations that were issued before their predicate was known. Each such operation takes one of a fixed number of slots. While it holds a slot it is under a write-block shadow. It may compute, but it may not write back. When the slot is allocated, it records which predicate bit governs it and whether zeroing applies to it.

The predicate register is treated as an ordinary source operand. The unit waits for a ready strobe from its producer and captures the value. In the following cycle it resolves every occupied slot at once, using each slot's own bit. A set bit releases the shadow so the result may commit. A clear bit either kills the operation or, when zeroing applies, turns it into a zero-result write. Each outcome is a one-cycle pulse, and the slot is then free again.

A flush input discards all pending work. It kills every shadowed slot and overrides any resolution due in the same cycle.

Top module: `pred_shadow_unit`

## Requirements
- R1: While reset is held and immediately after it, no slot is shadowed and no kill, zero or release pulse is driven.
- R2: A slot's shadow output goes high combinationally in the cycle an allocation targets that slot, which must be free. It stays high until the slot is resolved or flushed.
- R3: An allocation that targets a slot already shadowed is ignored. The slot keeps its original bit index and zeroing mode.
- R4: When the predicate-ready input is sampled high at clock edge E, every slot shadowed during the cycle after E is resolved at the next edge, and its pulse is visible in the cycle after that edge. A slot allocated at that resolving edge or later stays shadowed until a later predicate-ready event.
- R5: A slot whose recorded predicate bit is 1 receives a release pulse, and its shadow drops.
- R6: A slot whose recorded predicate bit is 0 with zeroing off receives a kill pulse, and its shadow drops.
- R7: A slot whose recorded predicate bit is 0 with zeroing on receives a zero pulse instead of a kill pulse, and its shadow drops.
- R8: Every pulse lasts exactly one cycle. A slot receives at most one of kill, zero and release per resolution, and it is free afterwards.
- R9: A flush kills every shadowed slot, with the kill pulse in the next cycle. It also blocks allocation in its own cycle and cancels a pending predicate-ready event. Flush takes priority over a resolution due at the same edge.
- R10: Each slot is resolved from bit `pred_value_i[idx]`, where idx is the bit index recorded at its allocation.
- R11: Slots that are not shadowed ignore predicate-ready events and receive no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all slots, killing shadowed ones |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_slot_i | input | SLOT_W | Target slot of the allocation |
| alloc_idx_i | input | IDX_W | Predicate bit index for the allocated slot |
| alloc_zero_i | input | 1 | Zeroing mode for the allocated slot |
| pred_ready_i | input | 1 | Predicate register written by its producer |
| pred_value_i | input | PRED_W | Predicate register value, sampled with pred_ready_i |
| shadow_o | output | NUM_SLOTS | Per-slot write-block shadow |
| kill_o | output | NUM_SLOTS | Per-slot kill pulse |
| zero_o | output | NUM_SLOTS | Per-slot zero-result pulse |
| release_o | output | NUM_SLOTS | Per-slot shadow-release pulse |

## Verification
The hardest situations to reach are the edge races. One is an allocation that lands exactly at the resolving edge. Another is a flush that coincides with that edge, or with the predicate-ready strobe itself. The stimulus times allocation and flush against the two-edge pipeline from ready strobe to pulse. It allocates in the same cycle as the ready strobe and again in the resolve cycle, and it flushes in each of those cycles. It then checks which slots were resolved, which were killed, and which kept their shadow.

// File: rtl/pred_shadow_pkg.sv
package pred_shadow_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_RELEASE = 2'd1,
    ACT_ZERO    = 2'd2,
    ACT_KILL    = 2'd3
  } psu_act_e;

  function automatic psu_act_e pick_act(input logic pbit, input logic zero_en);
    if (pbit)         return ACT_RELEASE;
    else if (zero_en) return ACT_ZERO;
    else              return ACT_KILL;
  endfunction

endpackage

// File: rtl/psu_alloc_dec.sv
module psu_alloc_dec #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_valid_i,
  input  logic [SLOT_W-1:0]    alloc_slot_i,
  input  logic                 flush_i,
  input  logic [NUM_SLOTS-1:0] busy_i,
  output logic [NUM_SLOTS-1:0] hit_o
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    assign hit_o[i] = alloc_valid_i && !flush_i && !busy_i[i] &&
                      (alloc_slot_i == SLOT_W'(i));
  end

  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)) else $error("multiple alloc hits"); // R2

  AST_NO_HIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & busy_i) == '0) else $error("alloc into busy slot"); // R3

endmodule

// File: rtl/psu_pred_latch.sv
module psu_pred_latch #(
  parameter int PRED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              pred_ready_i,
  input  logic [PRED_W-1:0] pred_value_i,
  output logic              resolve_o,
  output logic [PRED_W-1:0] value_o
);

  logic              pend_q;
  logic [PRED_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else begin
      pend_q <= pred_ready_i && !flush_i;
      if (pred_ready_i) val_q <= pred_value_i;
    end
  end

  assign resolve_o = pend_q;
  assign value_o   = val_q;

  AST_PEND_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_ready_i && !flush_i) |=> resolve_o) else $error("ready lost"); // R4

  AST_FLUSH_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !resolve_o) else $error("flush did not cancel"); // R9

endmodule

// File: rtl/psu_slot.sv
module psu_slot
  import pred_shadow_pkg::*;
#(
  parameter int PRED_W = 16,
  localparam int IDX_W = (PRED_W > 1) ? $clog2(PRED_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_hit_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic              alloc_zero_i,
  input  logic              resolve_i,
  input  logic [PRED_W-1:0] pred_value_i,
  output logic              busy_o,
  output logic              kill_o,
  output logic              zero_o,
  output logic              release_o
);

  logic             busy_q, zen_q;
  logic [IDX_W-1:0] idx_q;
  logic             kill_q, zpls_q, rel_q;
  psu_act_e         act_d;

  always_comb begin
    act_d = ACT_NONE;
    if (busy_q) begin
      if (flush_i)        act_d = ACT_KILL;
      else if (resolve_i) act_d = pick_act(pred_value_i[idx_q], zen_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      zen_q  <= 1'b0;
      idx_q  <= '0;
      kill_q <= 1'b0;
      zpls_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      kill_q <= (act_d == ACT_KILL);
      zpls_q <= (act_d == ACT_ZERO);
      rel_q  <= (act_d == ACT_RELEASE);
      if (act_d != ACT_NONE) begin
        busy_q <= 1'b0;
      end else if (alloc_hit_i) begin
        busy_q <= 1'b1;
        idx_q  <= alloc_idx_i;
        zen_q  <= alloc_zero_i;
      end
    end
  end

  assign busy_o    = busy_q;
  assign kill_o    = kill_q;
  assign zero_o    = zpls_q;
  assign release_o = rel_q;

  AST_ALLOC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_hit_i |=> busy_o) else $error("alloc not held"); // R2

  AST_RESOLVE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && resolve_i && !flush_i) |=> (kill_o || zero_o || release_o))
    else $error("resolution missing"); // R4

  AST_SET_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && resolve_i && !flush_i && pred_value_i[idx_q]) |=> release_o)
    else $error("set bit not released"); // R5

  AST_ZERO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && resolve_i && !flush_i && !pred_value_i[idx_q] && zen_q) |=> (zero_o && !kill_o))
    else $error("zeroing not applied"); // R7

  AST_FLUSH_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && flush_i) |=> (kill_o && !release_o && !zero_o))
    else $error("flush did not kill"); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kill_o, zero_o, release_o})) else $error("multiple outcomes"); // R8

  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o || zero_o || release_o) |=> !(kill_o || zero_o || release_o))
    else $error("pulse too long"); // R8

  AST_FREE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o || zero_o || release_o) |-> !busy_o) else $error("slot not freed"); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |=> !(kill_o || zero_o || release_o)) else $error("idle slot pulsed"); // R11

endmodule

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int NUM_SLOTS = 8,
  parameter int PRED_W    = 16,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W  = (PRED_W > 1) ? $clog2(PRED_W) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 alloc_valid_i,
  input  logic [SLOT_W-1:0]    alloc_slot_i,
  input  logic [IDX_W-1:0]     alloc_idx_i,
  input  logic                 alloc_zero_i,
  input  logic                 pred_ready_i,
  input  logic [PRED_W-1:0]    pred_value_i,
  output logic [NUM_SLOTS-1:0] shadow_o,
  output logic [NUM_SLOTS-1:0] kill_o,
  output logic [NUM_SLOTS-1:0] zero_o,
  output logic [NUM_SLOTS-1:0] release_o
);

  logic [NUM_SLOTS-1:0] busy, hit;
  logic                 resolve;
  logic [PRED_W-1:0]    pval;

  psu_alloc_dec #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_valid_i (alloc_valid_i),
    .alloc_slot_i  (alloc_slot_i),
    .flush_i       (flush_i),
    .busy_i        (busy),
    .hit_o         (hit)
  );

  psu_pred_latch #(.PRED_W(PRED_W)) u_pred (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .pred_ready_i (pred_ready_i),
    .pred_value_i (pred_value_i),
    .resolve_o    (resolve),
    .value_o      (pval)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    psu_slot #(.PRED_W(PRED_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush_i),
      .alloc_hit_i  (hit[i]),
      .alloc_idx_i  (alloc_idx_i),
      .alloc_zero_i (alloc_zero_i),
      .resolve_i    (resolve),
      .pred_value_i (pval),
      .busy_o       (busy[i]),
      .kill_o       (kill_o[i]),
      .zero_o       (zero_o[i]),
      .release_o    (release_o[i])
    );
  end

  // shadow raised in the allocation cycle itself
  assign shadow_o = busy | hit;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (kill_o == '0 && zero_o == '0 && release_o == '0))
    else $error("pulse after reset"); // R1

  AST_PULSE_DROPS_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kill_o | zero_o | release_o) & busy) == '0) else $error("shadow kept"); // R8

endmodule

// File: tb/pred_shadow_unit_test.sv
`timescale 1ns/1ps
module pred_shadow_unit_test;

  localparam int N  = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          a_valid = 1'b0;
  logic [2:0]    a_slot = '0;
  logic [3:0]    a_idx = '0;
  logic          a_zero = 1'b0;
  logic          p_ready = 1'b0;
  logic [PW-1:0] p_value = '0;
  logic [N-1:0]  shadow, kill, zero, rel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_shadow_unit #(.NUM_SLOTS(N), .PRED_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .alloc_valid_i(a_valid), .alloc_slot_i(a_slot), .alloc_idx_i(a_idx),
    .alloc_zero_i(a_zero), .pred_ready_i(p_ready), .pred_value_i(p_value),
    .shadow_o(shadow), .kill_o(kill), .zero_o(zero), .release_o(rel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [N-1:0] ek, input logic [N-1:0] ez,
                         input logic [N-1:0] er, input logic [N-1:0] es);
    chk({tag, " kill"}, 32'(kill), 32'(ek));
    chk({tag, " zero"}, 32'(zero), 32'(ez));
    chk({tag, " release"}, 32'(rel), 32'(er));
    chk({tag, " shadow"}, 32'(shadow), 32'(es));
  endtask

  task automatic do_alloc(input int s, input int idx, input logic zen, input string tag);
    @(negedge clk);
    a_valid = 1'b1; a_slot = 3'(s); a_idx = 4'(idx); a_zero = zen;
    #1 chk({tag, " shadow same cycle"}, 32'(shadow[s]), 32'd1);
    @(posedge clk); #1 a_valid = 1'b0;
  endtask

  task automatic pred_and_check(input logic [PW-1:0] v, input logic [N-1:0] ek,
                                input logic [N-1:0] ez, input logic [N-1:0] er,
                                input logic [N-1:0] es, input string tag);
    logic [N-1:0] sh0;
    @(negedge clk);
    p_ready = 1'b1; p_value = v;
    sh0 = shadow;
    @(posedge clk); #1 p_ready = 1'b0;
    @(negedge clk);
    chk_out({tag, " resolve cycle"}, '0, '0, '0, sh0);
    @(negedge clk);
    chk_out({tag, " pulse"}, ek, ez, er, es);
    @(negedge clk);
    chk_out({tag, " after pulse"}, '0, '0, '0, es);
  endtask

  // R1
  task automatic t_reset;
    #1 chk_out("R1 in reset", '0, '0, '0, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 after reset", '0, '0, '0, '0);
  endtask

  // R2 R5 R6 R7 R8 R10
  task automatic t_basic;
    do_alloc(0, 2, 1'b0, "R2 s0");
    do_alloc(1, 5, 1'b0, "R2 s1");
    do_alloc(2, 7, 1'b1, "R2 s2");
    do_alloc(3, 9, 1'b1, "R2 s3");
    @(negedge clk);
    chk("R2 shadow held", 32'(shadow), 32'h0f);
    pred_and_check(16'h0204, 8'h02, 8'h04, 8'h09, 8'h00, "R5 R6 R7 R10 R8");
  endtask

  // R3
  task automatic t_occupied;
    do_alloc(4, 0, 1'b0, "R3 first");
    do_alloc(4, 1, 1'b1, "R3 second");
    pred_and_check(16'h0001, 8'h00, 8'h00, 8'h10, 8'h00, "R3 kept original");
  endtask

  // R4
  task automatic t_timing;
    do_alloc(5, 3, 1'b0, "R4 s5");
    @(negedge clk);
    p_ready = 1'b1; p_value = 16'h0000;
    a_valid = 1'b1; a_slot = 3'd6; a_idx = 4'd3; a_zero = 1'b1;
    @(posedge clk); #1
    p_ready = 1'b0;
    a_slot = 3'd7; a_idx = 4'd3; a_zero = 1'b0;
    @(negedge clk);
    chk_out("R4 resolve cycle", '0, '0, '0, 8'hE0);
    @(posedge clk); #1 a_valid = 1'b0;
    @(negedge clk);
    chk_out("R4 pulse", 8'h20, 8'h40, 8'h00, 8'h80);
    @(negedge clk);
    chk_out("R4 late slot waits", '0, '0, '0, 8'h80);
    pred_and_check(16'h0008, 8'h00, 8'h00, 8'h80, 8'h00, "R4 next event");
  endtask

  // R9
  task automatic t_flush_prio;
    do_alloc(0, 0, 1'b0, "R9 s0");
    do_alloc(1, 1, 1'b1, "R9 s1");
    @(negedge clk);
    p_ready = 1'b1; p_value = 16'hffff;
    @(posedge clk); #1
    p_ready = 1'b0; flush = 1'b1;
    a_valid = 1'b1; a_slot = 3'd2; a_idx = 4'd0; a_zero = 1'b0;
    @(negedge clk);
    chk("R9 alloc blocked during flush", 32'(shadow[2]), 32'd0);
    @(posedge clk); #1 flush = 1'b0; a_valid = 1'b0;
    @(negedge clk);
    chk_out("R9 flush over resolve", 8'h03, '0, '0, '0);
    @(negedge clk);
    chk_out("R9 after flush", '0, '0, '0, '0);
  endtask

  // R9
  task automatic t_flush_pending;
    do_alloc(3, 0, 1'b0, "R9 s3");
    @(negedge clk);
    p_ready = 1'b1; p_value = 16'h0001; flush = 1'b1;
    @(posedge clk); #1 p_ready = 1'b0; flush = 1'b0;
    @(negedge clk);
    chk_out("R9 flush kills", 8'h08, '0, '0, '0);
    do_alloc(4, 0, 1'b0, "R9 s4");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_out("R9 pending cancelled", '0, '0, '0, 8'h10);
    end
    pred_and_check(16'h0001, '0, '0, 8'h10, '0, "R9 cleanup");
  endtask

  // R11
  task automatic t_idle;
    pred_and_check(16'hffff, '0, '0, '0, '0, "R11 idle");
    pred_and_check(16'h0000, '0, '0, '0, '0, "R11 idle zero");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_occupied();
    t_timing();
    t_flush_prio();
    t_flush_pending();
    t_idle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule